// File: doc/BRIEF.md
# D-PHY Lane Timing Calculator

This block turns a lane bit rate, given in whole Mbps, and a lane kind (clock lane or data lane) into the set of high-speed and escape-mode timing codes that a D-PHY lane needs. Three of the codes come from a table banded by rate: the prepare code, the zero code and the trail code. The zero code differs between clock and data lanes.

The remaining codes are computed arithmetically. The block derives a byte clock and an escape clock from the rate. It then converts fixed nanosecond minima, some of them scaled by the unit interval, into cycle counts of those clocks, rounding each count up. All divisions share one serial restoring divider, so one request occupies the block for a few hundred cycles.

Requests arrive on a valid/ready input. `in_ready` is high only while the block is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. While a computation runs, `in_ready` stays low and `in_valid` is disregarded, so the upstream side must hold off. When all codes are ready, `done` pulses for one cycle. The output codes then stay unchanged until the next completion.

Top module: `dphy_lane_timing`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0 and every timing output is 0, except `wake_hi` = 3 and `wake_lo` = 255.
- R2: A request is accepted when `in_valid` and `in_ready` are both 1 at a rising edge. From the next cycle `in_ready` is 0 until completion. `in_valid` pulses while `in_ready` is 0 change nothing. `in_rate_mbps` must be at least 1 whenever `in_valid` is 1.
- R3: Completion raises `done` for exactly one cycle, with `in_ready` already 1 in that cycle. All outputs hold their values between completions.
- R4: The band is the first one whose upper limit is at or above the rate. The limits are 110, 150, 200, 250, 300, 400, 500, 600, 700, 800 and 1000 Mbps, and any rate above 1000 uses the 1000 band. Each band gives (prepare, trail): 0x20/0x22, 0x06/0x45, 0x18/0x0B, 0x05/0x16, 0x51/0x2C, 0x64/0x33, 0x20/0x4E, 0x6A/0x3A, 0x3E/0x6A, 0x21/0x29, 0x09/0x27.
- R5: `hs_zero` comes from the chosen band and depends on `in_clk_lane` (1 = clock lane). The clock-lane codes per band are 0x16,0x16,0x17,0x17,0x18,0x19,0x1B,0x1D,0x1E,0x1F,0x20. The data-lane codes per band are 0x02,0x03,0x04,0x05,0x06,0x07,0x07,0x08,0x08,0x09,0x09.
- R6: Let R be the rate and UI = floor((1000 + floor(R/2)) / R) ns. Each count is ceil(T·R/8000) for its own time T: `hs_exit` uses T = 120, `clk_post` uses T = 70 + 52·UI, and `clk_pre` uses T = 8·UI.
- R7: `lpx` is c = ceil(60·R/8000), reduced by 2 only when c ≥ 2.
- R8: The escape divider is D = ceil(R/160) and the escape clock is E = floor(R·125000 / D) Hz. `ta_go`, `ta_sure` and `ta_get` are ceil(T·E / 10^9) for T = 240, 120 and 300 respectively.
- R9: `wake_hi` is always 3 and `wake_lo` is always 255.
- R10: Each computed count saturates at its field maximum: `hs_exit` 31, `clk_post` and `clk_pre` 15, and `lpx` and the three turnaround fields 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, request can be taken |
| in_rate_mbps | input | RATE_W (11) | Lane bit rate in Mbps |
| in_clk_lane | input | 1 | 1 = clock lane, 0 = data lane |
| done | output | 1 | One-cycle completion strobe |
| hs_prepare | output | 7 | HS prepare code |
| hs_zero | output | 6 | HS zero code |
| hs_trail | output | 7 | HS trail code |
| hs_exit | output | 5 | HS exit count (byte clock) |
| clk_post | output | 4 | Clock post count (byte clock) |
| clk_pre | output | 4 | Clock pre count (byte clock) |
| lpx | output | 6 | LPX count minus offset (byte clock) |
| ta_go | output | 6 | Turnaround go count (escape clock) |
| ta_sure | output | 6 | Turnaround sure count (escape clock) |
| ta_get | output | 6 | Turnaround get count (escape clock) |
| wake_hi | output | 2 | Wakeup high field |
| wake_lo | output | 8 | Wakeup low field |

## Verification
The assertions assume that `in_valid` never carries a zero rate. A zero rate would make the unit-interval division divide by zero, and the divider's exactness property is guarded only for non-zero divisors. The assertions also assume that requests follow the ready rule, so that the hold-stable and single-pulse properties describe real traffic. The directed stimulus uses only rates from 1 to 2047. It raises `in_valid` for a single cycle while `in_ready` is high. It raises `in_valid` during a busy period only in the scenario that checks such pulses are ignored.

// File: rtl/dphy_tim_pkg.sv
package dphy_tim_pkg;
  localparam int NUM_BANDS = 11;
  localparam int PREP_W    = 7;
  localparam int ZERO_W    = 6;
  localparam int TRAIL_W   = 7;
  localparam int EXIT_W    = 5;
  localparam int POST_W    = 4;
  localparam int PRE_W     = 4;
  localparam int LPX_W     = 6;
  localparam int TA_W      = 6;
  localparam int STEPS     = 10;

  typedef struct packed {
    logic [PREP_W-1:0]  prep;
    logic [ZERO_W-1:0]  zclk;
    logic [ZERO_W-1:0]  zdat;
    logic [TRAIL_W-1:0] trail;
  } band_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_t;
endpackage

// File: rtl/dphy_band_lut.sv
module dphy_band_lut
  import dphy_tim_pkg::*;
#(
  parameter int RATE_W = 11
) (
  input  logic [RATE_W-1:0]  rate,
  input  logic               clk_lane,
  output logic [PREP_W-1:0]  prep,
  output logic [ZERO_W-1:0]  zero,
  output logic [TRAIL_W-1:0] trail
);
  function automatic int band_limit(input int i);
    case (i)
      0: return 110;   1: return 150;   2: return 200;  3: return 250;
      4: return 300;   5: return 400;   6: return 500;  7: return 600;
      8: return 700;   9: return 800;   default: return 1000;
    endcase
  endfunction

  function automatic band_t band_row(input int i);
    case (i)
      0: return '{7'h20, 6'h16, 6'h02, 7'h22};
      1: return '{7'h06, 6'h16, 6'h03, 7'h45};
      2: return '{7'h18, 6'h17, 6'h04, 7'h0b};
      3: return '{7'h05, 6'h17, 6'h05, 7'h16};
      4: return '{7'h51, 6'h18, 6'h06, 7'h2c};
      5: return '{7'h64, 6'h19, 6'h07, 7'h33};
      6: return '{7'h20, 6'h1b, 6'h07, 7'h4e};
      7: return '{7'h6a, 6'h1d, 6'h08, 7'h3a};
      8: return '{7'h3e, 6'h1e, 6'h08, 7'h6a};
      9: return '{7'h21, 6'h1f, 6'h09, 7'h29};
      default: return '{7'h09, 6'h20, 6'h09, 7'h27};
    endcase
  endfunction

  logic [NUM_BANDS-1:0] hit;
  band_t                row;

  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_cmp
    assign hit[g] = ({1'b0, rate} <= (RATE_W+1)'(band_limit(g)));
  end

  always_comb begin
    row = band_row(NUM_BANDS-1);
    for (int i = NUM_BANDS-1; i >= 0; i--) begin
      if (hit[i]) row = band_row(i);
    end
  end

  assign prep  = row.prep;
  assign zero  = clk_lane ? row.zclk : row.zdat;
  assign trail = row.trail;
endmodule

// File: rtl/dphy_serial_div.sv
module dphy_serial_div #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W+1);

  logic [W:0]    rem_q;
  logic [W-1:0]  den_q;
  logic [W-1:0]  num_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [W:0]    rem_sh;
  logic          fits;

  always_comb begin
    rem_sh = {rem_q[W-1:0], quo[W-1]};
    fits   = (rem_sh >= {1'b0, den_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      quo    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      rem_q  <= '0;
      den_q  <= den;
      num_q  <= num;
      quo    <= num;
      cnt_q  <= CW'(W);
      busy_q <= 1'b1;
      done   <= 1'b0;
    end else if (busy_q) begin
      rem_q <= fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
      quo   <= {quo[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // quotient and remainder reconstruct the dividend (feeds R6/R8 counts)
  assert_div_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && den_q != '0) |->
      (({{W{1'b0}}, quo} * {{W{1'b0}}, den_q}) + {{(W-1){1'b0}}, rem_q}
        == {{W{1'b0}}, num_q}) && (rem_q < {1'b0, den_q}));

  assert_div_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/dphy_lane_timing.sv
module dphy_lane_timing
  import dphy_tim_pkg::*;
#(
  parameter int RATE_W       = 11,
  parameter int DIV_W        = 36,
  parameter int ESC_LIMIT_MHZ = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [RATE_W-1:0]  in_rate_mbps,
  input  logic               in_clk_lane,
  output logic               done,
  output logic [PREP_W-1:0]  hs_prepare,
  output logic [ZERO_W-1:0]  hs_zero,
  output logic [TRAIL_W-1:0] hs_trail,
  output logic [EXIT_W-1:0]  hs_exit,
  output logic [POST_W-1:0]  clk_post,
  output logic [PRE_W-1:0]   clk_pre,
  output logic [LPX_W-1:0]   lpx,
  output logic [TA_W-1:0]    ta_go,
  output logic [TA_W-1:0]    ta_sure,
  output logic [TA_W-1:0]    ta_get,
  output logic [1:0]         wake_hi,
  output logic [7:0]         wake_lo
);
  localparam int SW = $clog2(STEPS);
  localparam logic [DIV_W-1:0] C_NS_S   = DIV_W'(1000000000);
  localparam logic [DIV_W-1:0] C_BYTE_D = DIV_W'(8000);
  localparam logic [DIV_W-1:0] C_ESC_D  = DIV_W'(ESC_LIMIT_MHZ * 8);

  seq_t              state_q;
  logic [SW-1:0]     step_q;
  logic [RATE_W-1:0] rate_q;
  logic              lane_q;
  logic [DIV_W-1:0]  ui_q, escdiv_q, esc_q;
  logic [EXIT_W-1:0] w_exit;
  logic [POST_W-1:0] w_post;
  logic [PRE_W-1:0]  w_pre;
  logic [LPX_W-1:0]  w_lpx;
  logic [TA_W-1:0]   w_go, w_sure;

  logic              div_start, div_done;
  logic [DIV_W-1:0]  div_num, div_den, div_quo, rate_x, lpx_adj;
  logic [7:0]        s_exit, s_post, s_pre, s_lpx, s_ta;
  logic [PREP_W-1:0] lut_prep;
  logic [ZERO_W-1:0] lut_zero;
  logic [TRAIL_W-1:0] lut_trail;

  function automatic logic [7:0] sat_fld(input logic [DIV_W-1:0] v, input int w);
    logic [DIV_W-1:0] lim;
    lim = (DIV_W'(1) << w) - DIV_W'(1);
    return (v > lim) ? lim[7:0] : v[7:0];
  endfunction

  assign rate_x    = DIV_W'(rate_q);
  assign in_ready  = (state_q == ST_IDLE);
  assign div_start = (state_q == ST_ISSUE);
  assign wake_hi   = 2'b11;
  assign wake_lo   = 8'hff;

  always_comb begin
    div_den = C_BYTE_D;
    case (step_q)
      SW'(0): begin div_num = DIV_W'(1000) + (rate_x >> 1); div_den = rate_x; end
      SW'(1): begin div_num = rate_x + C_ESC_D - DIV_W'(1); div_den = C_ESC_D; end
      SW'(2): begin div_num = rate_x * DIV_W'(125000);      div_den = escdiv_q; end
      SW'(3): div_num = rate_x * DIV_W'(120) + C_BYTE_D - DIV_W'(1);
      SW'(4): div_num = (DIV_W'(70) + DIV_W'(52) * ui_q) * rate_x + C_BYTE_D - DIV_W'(1);
      SW'(5): div_num = DIV_W'(8) * ui_q * rate_x + C_BYTE_D - DIV_W'(1);
      SW'(6): div_num = rate_x * DIV_W'(60) + C_BYTE_D - DIV_W'(1);
      SW'(7): begin div_num = DIV_W'(240) * esc_q + C_NS_S - DIV_W'(1); div_den = C_NS_S; end
      SW'(8): begin div_num = DIV_W'(120) * esc_q + C_NS_S - DIV_W'(1); div_den = C_NS_S; end
      default: begin div_num = DIV_W'(300) * esc_q + C_NS_S - DIV_W'(1); div_den = C_NS_S; end
    endcase
  end

  always_comb begin
    lpx_adj = (div_quo >= DIV_W'(2)) ? div_quo - DIV_W'(2) : div_quo;
    s_exit  = sat_fld(div_quo, EXIT_W);
    s_post  = sat_fld(div_quo, POST_W);
    s_pre   = sat_fld(div_quo, PRE_W);
    s_lpx   = sat_fld(lpx_adj, LPX_W);
    s_ta    = sat_fld(div_quo, TA_W);
  end

  dphy_serial_div #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(div_num), .den(div_den), .done(div_done), .quo(div_quo)
  );

  dphy_band_lut #(.RATE_W(RATE_W)) u_lut (
    .rate(rate_q), .clk_lane(lane_q),
    .prep(lut_prep), .zero(lut_zero), .trail(lut_trail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      rate_q  <= '0;
      lane_q  <= 1'b0;
      ui_q    <= '0;
      escdiv_q <= '0;
      esc_q   <= '0;
      w_exit  <= '0; w_post <= '0; w_pre <= '0;
      w_lpx   <= '0; w_go   <= '0; w_sure <= '0;
      done    <= 1'b0;
      hs_prepare <= '0; hs_zero <= '0; hs_trail <= '0;
      hs_exit <= '0; clk_post <= '0; clk_pre <= '0; lpx <= '0;
      ta_go   <= '0; ta_sure <= '0; ta_get <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (in_valid) begin
          rate_q  <= in_rate_mbps;
          lane_q  <= in_clk_lane;
          step_q  <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        default: if (div_done) begin
          case (step_q)
            SW'(0): ui_q     <= div_quo;
            SW'(1): escdiv_q <= div_quo;
            SW'(2): esc_q    <= div_quo;
            SW'(3): w_exit   <= s_exit[EXIT_W-1:0];
            SW'(4): w_post   <= s_post[POST_W-1:0];
            SW'(5): w_pre    <= s_pre[PRE_W-1:0];
            SW'(6): w_lpx    <= s_lpx[LPX_W-1:0];
            SW'(7): w_go     <= s_ta[TA_W-1:0];
            SW'(8): w_sure   <= s_ta[TA_W-1:0];
            default: ;
          endcase
          if (step_q == SW'(STEPS-1)) begin
            state_q    <= ST_IDLE;
            done       <= 1'b1;
            hs_prepare <= lut_prep;
            hs_zero    <= lut_zero;
            hs_trail   <= lut_trail;
            hs_exit    <= w_exit;
            clk_post   <= w_post;
            clk_pre    <= w_pre;
            lpx        <= w_lpx;
            ta_go      <= w_go;
            ta_sure    <= w_sure;
            ta_get     <= s_ta[TA_W-1:0];
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
      endcase
    end
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_rate_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_rate_mbps != '0));

  assert_done_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({hs_prepare, hs_zero, hs_trail, hs_exit, clk_post,
                       clk_pre, lpx, ta_go, ta_sure, ta_get}));
endmodule

// File: tb/test_dphy_lane_timing.sv
module test_dphy_lane_timing;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [10:0] in_rate_mbps = '0;
  logic        in_clk_lane = 1'b0;
  logic        done;
  logic [6:0]  hs_prepare, hs_trail;
  logic [5:0]  hs_zero, lpx, ta_go, ta_sure, ta_get;
  logic [4:0]  hs_exit;
  logic [3:0]  clk_post, clk_pre;
  logic [1:0]  wake_hi;
  logic [7:0]  wake_lo;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dphy_lane_timing i_dphy_lane_timing (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_rate_mbps(in_rate_mbps), .in_clk_lane(in_clk_lane), .done(done),
    .hs_prepare(hs_prepare), .hs_zero(hs_zero), .hs_trail(hs_trail),
    .hs_exit(hs_exit), .clk_post(clk_post), .clk_pre(clk_pre), .lpx(lpx),
    .ta_go(ta_go), .ta_sure(ta_sure), .ta_get(ta_get),
    .wake_hi(wake_hi), .wake_lo(wake_lo)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint cdiv(input longint a, input longint b);
    return (a + b - 1) / b;
  endfunction

  function automatic longint sat(input longint v, input int w);
    longint lim = (longint'(1) << w) - 1;
    return (v > lim) ? lim : v;
  endfunction

  function automatic int band_of(input int r);
    int lims[11] = '{110, 150, 200, 250, 300, 400, 500, 600, 700, 800, 1000};
    for (int i = 0; i < 11; i++) if (r <= lims[i]) return i;
    return 10;
  endfunction

  task automatic check_all(input int r, input bit clk_ln, input string tag);
    int prep[11]  = '{'h20,'h06,'h18,'h05,'h51,'h64,'h20,'h6a,'h3e,'h21,'h09};
    int trl[11]   = '{'h22,'h45,'h0b,'h16,'h2c,'h33,'h4e,'h3a,'h6a,'h29,'h27};
    int zc[11]    = '{'h16,'h16,'h17,'h17,'h18,'h19,'h1b,'h1d,'h1e,'h1f,'h20};
    int zd[11]    = '{'h02,'h03,'h04,'h05,'h06,'h07,'h07,'h08,'h08,'h09,'h09};
    int b = band_of(r);
    longint ui  = (1000 + r / 2) / r;
    longint dv  = cdiv(r, 160);
    longint esc = (longint'(r) * 125000) / dv;
    longint lp  = cdiv(60 * r, 8000);
    if (lp >= 2) lp = lp - 2;
    check(tag, "R4 prepare", hs_prepare, prep[b]);
    check(tag, "R4 trail", hs_trail, trl[b]);
    check(tag, "R5 zero", hs_zero, clk_ln ? zc[b] : zd[b]);
    check(tag, "R6 exit", hs_exit, sat(cdiv(120 * r, 8000), 5));
    check(tag, "R6 clk_post", clk_post, sat(cdiv((70 + 52 * ui) * r, 8000), 4));
    check(tag, "R6 clk_pre", clk_pre, sat(cdiv(8 * ui * r, 8000), 4));
    check(tag, "R7 lpx", lpx, sat(lp, 6));
    check(tag, "R8 ta_go", ta_go, sat(cdiv(240 * esc, 1000000000), 6));
    check(tag, "R8 ta_sure", ta_sure, sat(cdiv(120 * esc, 1000000000), 6));
    check(tag, "R8 ta_get", ta_get, sat(cdiv(300 * esc, 1000000000), 6));
    check(tag, "R9 wake_hi", wake_hi, 3);
    check(tag, "R9 wake_lo", wake_lo, 255);
  endtask

  task automatic request(input int r, input bit clk_ln);
    int guard = 0;
    while (!in_ready && guard < 2000) begin @(negedge clk); guard++; end
    in_rate_mbps = 11'(r);
    in_clk_lane  = clk_ln;
    in_valid     = 1'b1;
    @(negedge clk);
    in_valid     = 1'b0;
    check("R2", "ready low after accept", in_ready, 0);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    check("R3", "done seen", done, 1);
    check("R3", "ready at done", in_ready, 1);
  endtask

  task automatic t_reset();
    check("R1", "ready", in_ready, 1);
    check("R1", "done", done, 0);
    check("R1", "prepare", hs_prepare, 0);
    check("R1", "zero", hs_zero, 0);
    check("R1", "lpx", lpx, 0);
    check("R1", "ta_get", ta_get, 0);
    check("R1", "wake_hi", wake_hi, 3);
    check("R1", "wake_lo", wake_lo, 255);
  endtask

  task automatic t_one(input int r, input bit clk_ln, input string tag);
    request(r, clk_ln);
    wait_done();
    check_all(r, clk_ln, tag);
  endtask

  task automatic t_hold();
    logic [6:0] p;
    logic [5:0] g;
    request(333, 1'b1);
    wait_done();
    p = hs_prepare;
    g = ta_get;
    @(negedge clk);
    check("R3", "done single cycle", done, 0);
    repeat (30) @(negedge clk);
    check("R3", "prepare held", hs_prepare, p);
    check("R3", "ta_get held", ta_get, g);
  endtask

  task automatic t_ignore_busy();
    int guard = 0;
    request(90, 1'b0);
    repeat (5) @(negedge clk);
    in_rate_mbps = 11'd1500;
    in_clk_lane  = 1'b1;
    in_valid     = 1'b1;
    repeat (3) @(negedge clk);
    in_valid     = 1'b0;
    check("R2", "ready stays low while busy", in_ready, 0);
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    check_all(90, 1'b0, "R2 busy-ignore");
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_one(110, 1'b1, "R4 band edge 110 clock");
    t_one(111, 1'b1, "R4 band edge 111 clock");
    t_one(111, 1'b0, "R5 data lane");
    t_one(250, 1'b0, "R4 band 250");
    t_one(1000, 1'b1, "R4 band 1000");
    t_one(1001, 1'b0, "R4 above top band");
    t_one(16, 1'b0, "R7 small lpx");
    t_one(1, 1'b1, "R6 min rate");
    t_one(640, 1'b0, "R8 escape divider");
    t_one(2047, 1'b1, "R10 saturation");
    t_hold();
    t_ignore_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule